// File: doc/BRIEF.md
# Programmable Memory Chip-Select Unit

This block turns each bus cycle into at most one active-low chip select. It samples a 20-bit address, a memory/I/O flag and two byte-lane write enables when a cycle starts. From these it picks one of three targets. The upper memory region always ends at the top of the address space. The lower memory region always starts at address zero. The third target is a 1-Kbyte peripheral block that can be moved anywhere. It is split into eight 128-byte regions, and each region has its own select. Either memory region can be put into DRAM mode. In that mode it drives a row strobe for its bank and two byte-lane column strobes instead of its plain select.

The cycle is tracked by three states. `ST_IDLE` waits for a start. `ST_ADDR` is the address phase. `ST_DATA` is the data phase and can be extended. The transitions are named as follows:
- `IDLE->ADDR` is taken on an accepted start.
- `ADDR->DATA` is taken unconditionally.
- `DATA->DATA` is taken while the end strobe is low.
- `DATA->IDLE` is taken on the end strobe.

Memory selects and row strobes assert in the address phase. Peripheral selects and column strobes assert one phase later. A small write port programs the region sizes, the peripheral base, the peripheral space and the DRAM modes. Output enables tell the pads when to float the upper and peripheral selects.

Top module: `memsel_unit`

## Requirements
- R1: After reset, all selects and strobes are high (inactive). The upper region covers F0000h to FFFFFh in memory space. The lower region and the peripheral block are both disabled.
- R2: Register 0 bits [9:0] give the upper size in Kbytes as a one-hot code: bit k means 2^k Kbytes. The region starts at 100000h minus the size. A write with no bit set, or with more than one bit set, is ignored.
- R3: Register 1 bits [9:0] give the lower size with the same one-hot code, starting at address 0. The value 0 disables the lower region. A nonzero value that is not one-hot is ignored.
- R4: Register 2 holds the peripheral block settings:
  - bits [9:0] are address bits [19:10] of the block base;
  - bit 10 selects memory space when 1 and I/O space when 0;
  - bit 11 enables the block.
  
  Select n asserts for offset n*128 to n*128+127, so n equals address bits [9:7].
- R5: A plain memory select goes low in the address phase, the first cycle after an accepted start. It stays low through the data phase. A peripheral select goes low one cycle after the memory select would. Every output returns high in the cycle after the end strobe is seen in `ST_DATA`.
- R6: An access that hits the peripheral block asserts only the peripheral select, even when a memory region also matches. At most one select or row strobe is ever low.
- R7: Register 3 bit 0 puts the upper region in DRAM mode, and bit 1 does the same for the lower region. In DRAM mode the plain select stays high. Row strobe 1 then serves the upper bank, and row strobe 0 serves the lower bank, both timed like the plain select.
- R8: In DRAM mode the column strobes go low in the data phase and rise together with the row strobe. Column strobe 0 is the low byte and column strobe 1 is the high byte. A write asserts only the lanes whose write enables were high at the start. A read, where neither enable is high, asserts both lanes.
- R9: `up_oe` and `per_oe` are low while reset is asserted and while `bus_held` is high, and high otherwise.
- R10: A start strobe is ignored while `bus_held` is high and while a cycle is in progress. Address changes after the start do not alter the current selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address, sampled at cycle start |
| is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| wr_lo | input | 1 | Low-byte write enable |
| wr_hi | input | 1 | High-byte write enable |
| cyc_start | input | 1 | Start of bus cycle |
| cyc_end | input | 1 | End of bus cycle, taken in the data phase |
| bus_held | input | 1 | Bus granted to another master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register number |
| cfg_data | input | 16 | Configuration write data |
| up_cs_n | output | 1 | Upper memory select |
| lo_cs_n | output | 1 | Lower memory select |
| per_cs_n | output | 8 | Peripheral region selects |
| ras_n | output | 2 | Row strobes: [1] upper bank, [0] lower bank |
| cas_n | output | 2 | Column strobes: [1] high byte, [0] low byte |
| up_oe | output | 1 | Output enable for the upper select |
| per_oe | output | 1 | Output enable for the peripheral selects |

## Verification
The checker assumes that the cycle phase it is given comes from the block's own state register. It also assumes that `bus_held` changes only between edges, so an idle state with the bus held always stays idle on the next edge. The bench drives every input at the falling edge. It raises `cyc_start` only from idle or, on purpose, in an extended data phase to show that the start is ignored there. It raises `cyc_end` only once the data phase has been reached. The bench changes the configuration only between bus cycles, so the decode captured at a start always matches the bench model that computed its expectations.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;
    localparam int ADDR_W      = 20;
    localparam int GRAN_W      = 10;
    localparam int PCS_NUM     = 8;
    localparam int CFG_W       = 16;
    localparam int SZ_W        = ADDR_W - GRAN_W;
    localparam int PIDX_W      = $clog2(PCS_NUM);
    localparam int UP_RST_LOG2 = 6;

    localparam logic [1:0] REG_UP   = 2'd0;
    localparam logic [1:0] REG_LO   = 2'd1;
    localparam logic [1:0] REG_PER  = 2'd2;
    localparam logic [1:0] REG_MODE = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic [SZ_W-1:0] up_size;
        logic [SZ_W-1:0] lo_size;
        logic [SZ_W-1:0] per_base;
        logic            per_mem;
        logic            per_en;
        logic            up_dram;
        logic            lo_dram;
    } cfg_t;

    typedef struct packed {
        logic              up;
        logic              lo;
        logic              per;
        logic [PIDX_W-1:0] idx;
        logic              up_dram;
        logic              lo_dram;
    } hit_t;
endpackage

// File: rtl/memsel_cfg.sv
`timescale 1ns/1ps
module memsel_cfg
    import memsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    output cfg_t             cfg
);
    localparam int PER_MEM_BIT = SZ_W;
    localparam int PER_EN_BIT  = SZ_W + 1;

    logic [SZ_W-1:0] size_fld;
    logic            size_pow2;

    assign size_fld  = cfg_data[SZ_W-1:0];
    assign size_pow2 = (size_fld != '0) && ((size_fld & (size_fld - SZ_W'(1))) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.up_size  <= SZ_W'(1) << UP_RST_LOG2;
            cfg.lo_size  <= '0;
            cfg.per_base <= '0;
            cfg.per_mem  <= 1'b0;
            cfg.per_en   <= 1'b0;
            cfg.up_dram  <= 1'b0;
            cfg.lo_dram  <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                REG_UP: begin
                    if (size_pow2) cfg.up_size <= size_fld;
                end
                REG_LO: begin
                    if (size_pow2 || size_fld == '0) cfg.lo_size <= size_fld;
                end
                REG_PER: begin
                    cfg.per_base <= size_fld;
                    cfg.per_mem  <= cfg_data[PER_MEM_BIT];
                    cfg.per_en   <= cfg_data[PER_EN_BIT];
                end
                REG_MODE: begin
                    cfg.up_dram <= cfg_data[0];
                    cfg.lo_dram <= cfg_data[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/memsel_decode.sv
`timescale 1ns/1ps
module memsel_decode
    import memsel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    input  cfg_t              cfg,
    output hit_t              hit
);
    localparam int OFS_MSB = GRAN_W - 1;

    logic [SZ_W-1:0] blk;
    logic [SZ_W-1:0] up_mask;
    logic [SZ_W-1:0] lo_mask;
    logic            up_raw;
    logic            lo_raw;
    logic            per_raw;

    always_comb begin
        blk     = addr[ADDR_W-1:GRAN_W];
        up_mask = ~(cfg.up_size - SZ_W'(1));
        lo_mask = ~(cfg.lo_size - SZ_W'(1));
        up_raw  = is_mem && ((blk & up_mask) == up_mask);
        lo_raw  = is_mem && (cfg.lo_size != '0) && ((blk & lo_mask) == '0);
        per_raw = cfg.per_en && (is_mem == cfg.per_mem) && (blk == cfg.per_base);

        hit.per     = per_raw;
        hit.up      = up_raw && !per_raw;
        hit.lo      = lo_raw && !per_raw && !up_raw;
        hit.idx     = addr[OFS_MSB -: PIDX_W];
        hit.up_dram = cfg.up_dram;
        hit.lo_dram = cfg.lo_dram;
    end
endmodule

// File: rtl/memsel_fsm.sv
`timescale 1ns/1ps
module memsel_fsm
    import memsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               cyc_end,
    input  logic               bus_held,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  hit_t               hit_in,
    output bus_st_e            phase,
    output logic               up_cs_n,
    output logic               lo_cs_n,
    output logic [PCS_NUM-1:0] per_cs_n,
    output logic [1:0]         ras_n,
    output logic [1:0]         cas_n
);
    bus_st_e    st_q;
    bus_st_e    st_nx;
    hit_t       hit_q;
    logic [1:0] lane_q;
    logic       accept;
    logic       in_act;
    logic       in_data;
    logic       dram_hit;

    assign accept = (st_q == ST_IDLE) && cyc_start && !bus_held;
    assign phase  = st_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)  st_nx = ST_ADDR;
            ST_ADDR:              st_nx = ST_DATA;
            ST_DATA: if (cyc_end) st_nx = ST_IDLE;
            default:              st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= '0;
            lane_q <= '0;
        end else if (accept) begin
            hit_q     <= hit_in;
            lane_q[0] <= wr_lo || !(wr_lo || wr_hi);
            lane_q[1] <= wr_hi || !(wr_lo || wr_hi);
        end
    end

    always_comb begin
        in_act   = (st_q == ST_ADDR) || (st_q == ST_DATA);
        in_data  = (st_q == ST_DATA);
        dram_hit = (hit_q.up && hit_q.up_dram) || (hit_q.lo && hit_q.lo_dram);
        up_cs_n  = !(in_act && hit_q.up && !hit_q.up_dram);
        lo_cs_n  = !(in_act && hit_q.lo && !hit_q.lo_dram);
        ras_n[1] = !(in_act && hit_q.up && hit_q.up_dram);
        ras_n[0] = !(in_act && hit_q.lo && hit_q.lo_dram);
        cas_n[0] = !(in_data && dram_hit && lane_q[0]);
        cas_n[1] = !(in_data && dram_hit && lane_q[1]);
    end

    for (genvar g = 0; g < PCS_NUM; g++) begin : g_pcs
        assign per_cs_n[g] = !(in_data && hit_q.per && (hit_q.idx == PIDX_W'(g)));
    end
endmodule

// File: rtl/memsel_unit.sv
`timescale 1ns/1ps
module memsel_unit
    import memsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_mem,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic               cyc_start,
    input  logic               cyc_end,
    input  logic               bus_held,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_data,
    output logic               up_cs_n,
    output logic               lo_cs_n,
    output logic [PCS_NUM-1:0] per_cs_n,
    output logic [1:0]         ras_n,
    output logic [1:0]         cas_n,
    output logic               up_oe,
    output logic               per_oe
);
    cfg_t    cfg;
    hit_t    hit;
    bus_st_e bus_phase;

    memsel_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .cfg      (cfg)
    );

    memsel_decode u_dec (
        .addr   (addr),
        .is_mem (is_mem),
        .cfg    (cfg),
        .hit    (hit)
    );

    memsel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .bus_held  (bus_held),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .hit_in    (hit),
        .phase     (bus_phase),
        .up_cs_n   (up_cs_n),
        .lo_cs_n   (lo_cs_n),
        .per_cs_n  (per_cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    assign up_oe  = rst_n && !bus_held;
    assign per_oe = rst_n && !bus_held;
endmodule

// File: rtl/memsel_unit_chk.sv
`timescale 1ns/1ps
module memsel_unit_chk
    import memsel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_held,
    input bus_st_e            phase,
    input logic               up_cs_n,
    input logic               lo_cs_n,
    input logic [PCS_NUM-1:0] per_cs_n,
    input logic [1:0]         ras_n,
    input logic [1:0]         cas_n,
    input logic               up_oe,
    input logic               per_oe
);
    // R6
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~up_cs_n, ~lo_cs_n, ~per_cs_n, ~ras_n}));

    // R5
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_ADDR) |-> ((&per_cs_n) && (&cas_n)));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE) |-> (up_cs_n && lo_cs_n && (&per_cs_n) && (&ras_n) && (&cas_n)));

    // R8
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cas_n) |-> !(&ras_n));

    // R9
    hiz_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_held |-> (!up_oe && !per_oe));

    // R10
    held_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE && bus_held) |=> (phase == ST_IDLE));
endmodule

bind memsel_unit memsel_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_held (bus_held),
    .phase    (bus_phase),
    .up_cs_n  (up_cs_n),
    .lo_cs_n  (lo_cs_n),
    .per_cs_n (per_cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .up_oe    (up_oe),
    .per_oe   (per_oe)
);

// File: tb/memsel_unit_bench.sv
`timescale 1ns/1ps
module memsel_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        is_mem = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
    logic        cyc_start = 1'b0, cyc_end = 1'b0, bus_held = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        up_cs_n, lo_cs_n, up_oe, per_oe;
    logic [7:0]  per_cs_n;
    logic [1:0]  ras_n, cas_n;

    memsel_unit u_memsel_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .is_mem(is_mem),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .bus_held(bus_held), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .up_cs_n(up_cs_n), .lo_cs_n(lo_cs_n), .per_cs_n(per_cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .up_oe(up_oe), .per_oe(per_oe)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [13:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    localparam logic [13:0] QUIET = 14'h3FFF;

    // bench model of the programmed state
    int m_up_kb = 64, m_lo_kb = 0, m_pbase = 0;
    bit m_pmem = 0, m_pen = 0, m_ud = 0, m_ld = 0;

    function automatic logic [13:0] outs();
        return {up_cs_n, lo_cs_n, per_cs_n, ras_n, cas_n};
    endfunction

    task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] expect_vec(int a, bit m, bit wl, bit wh, bit dphase);
        bit hp, hu, hl;
        logic up, lo, r1, r0, c1, c0;
        logic [7:0] pc;
        hp = m_pen && (m == m_pmem) && a >= m_pbase && a < m_pbase + 1024;
        hu = !hp && m && a >= 'h100000 - m_up_kb * 1024;
        hl = !hp && !hu && m && m_lo_kb > 0 && a < m_lo_kb * 1024;
        up = !(hu && !m_ud);
        lo = !(hl && !m_ld);
        r1 = !(hu && m_ud);
        r0 = !(hl && m_ld);
        pc = 8'hFF;
        if (dphase && hp) pc[(a - m_pbase) / 128] = 1'b0;
        c0 = !(dphase && ((hu && m_ud) || (hl && m_ld)) && (wl || !(wl || wh)));
        c1 = !(dphase && ((hu && m_ud) || (hl && m_ld)) && (wh || !(wl || wh)));
        return {up, lo, pc, r1, r0, c1, c0};
    endfunction

    task automatic push(logic [13:0] v, string req);
        exp_t e;
        e.val = v;
        e.req = req;
        q.push_back(e);
    endtask

    // monitor: compares one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, outs(), e.val);
            end
        end
    end

    task automatic wcfg(logic [1:0] s, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bus_cycle(int a, bit m, bit wl, bit wh, int hold, string req);
        @(negedge clk);
        addr = 20'(a); is_mem = m; wr_lo = wl; wr_hi = wh; cyc_start = 1'b1;
        @(posedge clk); #1;
        push(expect_vec(a, m, wl, wh, 1'b0), req);
        @(negedge clk);
        cyc_start = 1'b0;
        @(posedge clk); #1;
        push(expect_vec(a, m, wl, wh, 1'b1), req);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            cyc_start = 1'b1;
            addr = 20'(a) ^ 20'h80000;
            is_mem = !m;
            @(posedge clk); #1;
            push(expect_vec(a, m, wl, wh, 1'b1), "R10 restart in data phase");
        end
        @(negedge clk);
        cyc_end = 1'b1;
        @(posedge clk); #1;
        push(QUIET, "R5 release after end");
        @(negedge clk);
        cyc_end = 1'b0; cyc_start = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: enables low and outputs quiet while in reset (R1)
        #25;
        chk("R9 oe in reset", {12'h0, up_oe, per_oe}, 14'h0);
        chk("R1 quiet in reset", outs(), QUIET);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 oe after reset", {12'h0, up_oe, per_oe}, 14'h3);

        // R1: reset upper window F0000-FFFFF, lower and peripheral off
        bus_cycle('hFFFF0, 1, 0, 0, 0, "R1 reset fetch");
        bus_cycle('hF0000, 1, 0, 0, 0, "R1 upper start");
        bus_cycle('hEFFFF, 1, 0, 0, 0, "R1 below upper");
        bus_cycle('hFFFF0, 0, 0, 0, 0, "R1 io space no upper");
        bus_cycle('h00100, 1, 0, 0, 0, "R1 lower off");

        // R2: 128 KB upper, then an invalid code that must be ignored
        wcfg(2'd0, 16'h0080); m_up_kb = 128;
        bus_cycle('hE0000, 1, 0, 0, 0, "R2 upper 128K start");
        bus_cycle('hDFFFF, 1, 0, 0, 0, "R2 below 128K");
        wcfg(2'd0, 16'h00C0);
        bus_cycle('hE0000, 1, 0, 0, 0, "R2 invalid code ignored");

        // R3: lower 64 KB, ignore invalid, disable, re-enable 4 KB
        wcfg(2'd1, 16'h0040); m_lo_kb = 64;
        bus_cycle('h0FFFF, 1, 0, 0, 0, "R3 lower top");
        bus_cycle('h10000, 1, 0, 0, 0, "R3 past lower");
        wcfg(2'd1, 16'h0003);
        bus_cycle('h0FFFF, 1, 0, 0, 0, "R3 invalid code ignored");
        wcfg(2'd1, 16'h0000); m_lo_kb = 0;
        bus_cycle('h00000, 1, 0, 0, 0, "R3 lower disabled");
        wcfg(2'd1, 16'h0004); m_lo_kb = 4;
        bus_cycle('h00FFF, 1, 0, 0, 0, "R3 lower 4K");

        // R4: peripheral block at 80000h in I/O space
        wcfg(2'd2, 16'h0A00); m_pen = 1; m_pmem = 0; m_pbase = 'h80000;
        bus_cycle('h80000, 0, 0, 0, 0, "R4 region 0");
        bus_cycle('h80385, 0, 0, 0, 0, "R4 region 7");
        bus_cycle('h80100, 0, 0, 0, 0, "R4 region 2");
        bus_cycle('h80000, 1, 0, 0, 0, "R4 wrong space");
        bus_cycle('h80400, 0, 0, 0, 0, "R4 past block");

        // R6: peripheral block in memory space overlapping the upper region
        wcfg(2'd2, 16'h0FC0); m_pmem = 1; m_pbase = 'hF0000;
        bus_cycle('hF0180, 1, 0, 0, 0, "R6 peripheral over upper");
        bus_cycle('hF0400, 1, 0, 0, 0, "R6 upper beside block");

        // R10: start pulses and address changes during the data phase
        bus_cycle('hF0080, 1, 0, 0, 2, "R10 long peripheral cycle");
        bus_cycle('hE1000, 1, 0, 0, 2, "R10 long upper cycle");

        // R7/R8: DRAM modes
        wcfg(2'd3, 16'h0001); m_ud = 1;
        bus_cycle('hFFFF0, 1, 0, 0, 0, "R7 R8 upper dram read");
        bus_cycle('hFFFF0, 1, 1, 0, 0, "R8 upper dram low byte write");
        bus_cycle('hFFFF0, 1, 1, 1, 1, "R8 upper dram word write");
        wcfg(2'd3, 16'h0003); m_ld = 1;
        bus_cycle('h00010, 1, 0, 1, 0, "R7 R8 lower dram high byte write");
        bus_cycle('h00010, 1, 0, 0, 0, "R8 lower dram read");

        // R9/R10: bus held floats outputs and blocks a start
        @(negedge clk);
        bus_held = 1'b1; addr = 20'hFFFF0; is_mem = 1'b1; cyc_start = 1'b1;
        #1;
        chk("R9 oe while held", {12'h0, up_oe, per_oe}, 14'h0);
        @(posedge clk); #1;
        push(QUIET, "R10 start ignored while held");
        @(negedge clk);
        cyc_start = 1'b0;
        @(posedge clk); #1;
        push(QUIET, "R10 still idle after held start");
        @(negedge clk);
        bus_held = 1'b0;
        #1;
        chk("R9 oe released", {12'h0, up_oe, per_oe}, 14'h3);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule